// File: doc/BRIEF.md
# Packed-Halfword 40-Bit Multiply-Accumulate Unit

This block is an execution datapath that holds a single 40-bit signed accumulator. It sits behind an instruction decoder that has already checked the condition and fetched two 32-bit register operands. Three multiply-accumulate flavours are offered. The first is a full 32x32 signed multiply whose product is cut to 40 bits. The second is a dual packed-halfword mode that adds two 16x16 signed products in one step. The third is a single 16x16 signed multiply whose halves are picked by two select bits. Every addition wraps modulo 2^40, and no condition flags are produced.

Software state moves in and out through two 32-bit words. A write loads the low word and the low byte of the high word into the accumulator. A read returns the low 32 bits, along with the top byte sign-extended to a full word. The read strobe is separate from the operation strobe. This lets a context save run in the same cycle as a multiply-accumulate, and the read then sees the value from before the update. Each request completes one clock after its strobe, and a done pulse marks that cycle.

Top module: `pkmac_unit`

## Requirements
- R1: Op code 0 (full-word MAC) adds bits [39:0] of the signed 64-bit product opnd_a x opnd_b to the accumulator.
- R2: Op code 1 (dual MAC) forms two signed 16x16 products, one from bits [15:0] of both operands and one from bits [31:16] of both, sign-extends each to 40 bits, and adds both to the accumulator in one operation.
- R3: Op code 2 (single-half MAC) multiplies one signed half of opnd_a by one signed half of opnd_b. The half of opnd_a is chosen by sel_a and the half of opnd_b by sel_b, where 1 picks bits [31:16] and 0 picks bits [15:0]. The product is sign-extended and added.
- R4: Accumulator additions wrap modulo 2^40, with no saturation and no flag.
- R5: Op code 3 (load) sets accumulator bits [31:0] to wr_lo and bits [39:32] to wr_hi[7:0]. Bits wr_hi[31:8] are ignored.
- R6: A cycle with rd_req high makes rd_lo = accumulator[31:0] and rd_hi = accumulator[39:32] sign-extended to 32 bits, both visible in the next cycle and held until the next read.
- R7: When rd_req and an operation share a cycle, the read returns the accumulator value from before that operation.
- R8: done is high for exactly the one cycle after any cycle in which in_valid or rd_req is high, and low otherwise.
- R9: Op codes 4 to 7, and any cycle with in_valid low, leave the accumulator unchanged.
- R10: A synchronous active-low reset clears the accumulator, rd_lo, rd_hi and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code (0 word MAC, 1 dual MAC, 2 half MAC, 3 load) |
| opnd_a | input | 32 | Multiplicand operand |
| opnd_b | input | 32 | Multiplier operand |
| sel_a | input | 1 | Half select for opnd_a in single-half MAC |
| sel_b | input | 1 | Half select for opnd_b in single-half MAC |
| wr_lo | input | 32 | Load value for accumulator bits [31:0] |
| wr_hi | input | 32 | Load value; bits [7:0] go to accumulator bits [39:32] |
| rd_req | input | 1 | Read strobe |
| rd_lo | output | 32 | Accumulator bits [31:0] from the last read |
| rd_hi | output | 32 | Sign-extended accumulator bits [39:32] from the last read |
| done | output | 1 | Completion pulse |

## Verification
The bench builds the unit with its default parameters: a 40-bit accumulator, 32-bit operands and 16-bit halves, which gives two packed lanes. This width lets a single load place the accumulator one step below positive overflow or at all ones, so one small multiply-accumulate shows the wrap from +2^39-1 to -2^39 and from -1 to 0. It also reaches the negative-times-negative halfword case, where the two summed lane products cross bit 31 but not bit 39. That is the point at which a 32-bit intermediate would give a wrong result.

// File: rtl/pkmac_pkg.sv
// pkmac_pkg: shared widths and operation codes for the multiply-accumulate unit.
// Assumes operands split into an integral number of halfword lanes.
package pkmac_pkg;
    localparam int unsigned ACC_W  = 40;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_MAC_WORD = 3'd0,
        OP_MAC_DUAL = 3'd1,
        OP_MAC_HALF = 3'd2,
        OP_LOAD     = 3'd3
    } pkmac_op_e;
endpackage

// File: rtl/pkmac_addend.sv
// pkmac_addend: combinational product former. For a MAC op code it yields the
// 40-bit value to add to the accumulator and raises is_mac; otherwise is_mac=0.
// Assumes two halfword lanes per operand (select bits are one bit wide).
// All arithmetic is done at ACC_W bits on sign-extended operands, so the
// result equals the true signed product reduced modulo 2^ACC_W.
module pkmac_addend
    import pkmac_pkg::*;
#(
    parameter int unsigned P_ACC_W  = ACC_W,
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_HALF_W = HALF_W
) (
    input  logic [OP_W-1:0]     op,
    input  logic [P_DATA_W-1:0] a,
    input  logic [P_DATA_W-1:0] b,
    input  logic                sel_a,
    input  logic                sel_b,
    output logic [P_ACC_W-1:0]  addend,
    output logic                is_mac
);
    localparam int unsigned LANES  = P_DATA_W / P_HALF_W;
    localparam int unsigned WEXT   = P_ACC_W - P_DATA_W;
    localparam int unsigned HEXT   = P_ACC_W - P_HALF_W;

    logic [P_ACC_W-1:0] word_prod;
    logic [P_ACC_W-1:0] lane_prod [LANES];
    logic [P_ACC_W-1:0] dual_sum;
    logic [P_ACC_W-1:0] half_prod;
    logic [P_HALF_W-1:0] half_a, half_b;

    // Full-word product: sign-extended operands, low ACC_W bits kept.
    assign word_prod = {{WEXT{a[P_DATA_W-1]}}, a} * {{WEXT{b[P_DATA_W-1]}}, b};

    // One signed product per halfword lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [P_HALF_W-1:0] la, lb;
        assign la = a[g*P_HALF_W +: P_HALF_W];
        assign lb = b[g*P_HALF_W +: P_HALF_W];
        assign lane_prod[g] = {{HEXT{la[P_HALF_W-1]}}, la} * {{HEXT{lb[P_HALF_W-1]}}, lb};
    end

    // Sum of all lane products for the dual mode.
    always_comb begin
        dual_sum = '0;
        for (int i = 0; i < LANES; i++) dual_sum = dual_sum + lane_prod[i];
    end

    // Selected halves for the single-half mode.
    assign half_a    = sel_a ? a[P_DATA_W-1 -: P_HALF_W] : a[P_HALF_W-1:0];
    assign half_b    = sel_b ? b[P_DATA_W-1 -: P_HALF_W] : b[P_HALF_W-1:0];
    assign half_prod = {{HEXT{half_a[P_HALF_W-1]}}, half_a} * {{HEXT{half_b[P_HALF_W-1]}}, half_b};

    // Choose the addend for the decoded op code.
    always_comb begin
        addend = '0;
        is_mac = 1'b1;
        unique case (op)
            OP_MAC_WORD: addend = word_prod;
            OP_MAC_DUAL: addend = dual_sum;
            OP_MAC_HALF: addend = half_prod;
            default:     is_mac = 1'b0;
        endcase
    end
endmodule

// File: rtl/pkmac_acc.sv
// pkmac_acc: the accumulator register. Adds the addend when add_en, loads the
// load value when load_en, otherwise holds. Assumes add_en and load_en are
// never both high (the top decodes them from one op code).
module pkmac_acc
    import pkmac_pkg::*;
#(
    parameter int unsigned P_ACC_W = ACC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               add_en,
    input  logic               load_en,
    input  logic [P_ACC_W-1:0] addend,
    input  logic [P_ACC_W-1:0] load_val,
    output logic [P_ACC_W-1:0] acc_q
);
    // Accumulator update with modular add, load or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (load_en) acc_q <= load_val;
        else if (add_en)  acc_q <= acc_q + addend;
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(add_en || load_en) |=> $stable(acc_q));
    assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> acc_q == $past(load_val));
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> acc_q == '0);
endmodule

// File: rtl/pkmac_readout.sv
// pkmac_readout: captures the accumulator on a read strobe into the low and
// sign-extended high output words, and forms the done pulse. Assumes the
// accumulator is wider than the data word and at most twice as wide.
module pkmac_readout
    import pkmac_pkg::*;
#(
    parameter int unsigned P_ACC_W  = ACC_W,
    parameter int unsigned P_DATA_W = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_req,
    input  logic                any_req,
    input  logic [P_ACC_W-1:0]  acc,
    output logic [P_DATA_W-1:0] rd_lo,
    output logic [P_DATA_W-1:0] rd_hi,
    output logic                done
);
    localparam int unsigned TOP_W = P_ACC_W - P_DATA_W;
    localparam int unsigned SX_W  = 2 * P_DATA_W - P_ACC_W;

    // Read capture of the pre-update accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_lo <= '0;
            rd_hi <= '0;
        end else if (rd_req) begin
            rd_lo <= acc[P_DATA_W-1:0];
            rd_hi <= {{SX_W{acc[P_ACC_W-1]}}, acc[P_ACC_W-1 -: TOP_W]};
        end
    end

    // Completion pulse one cycle after any request.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= any_req;
    end

    assert_read_pre_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_lo == $past(acc[P_DATA_W-1:0]));
    assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_lo) && $stable(rd_hi));
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> !done);
endmodule

// File: rtl/pkmac_unit.sv
// pkmac_unit: top of the 40-bit packed-halfword multiply-accumulate unit.
// Decodes the op code into add/load enables, forms the addend, updates the
// accumulator and serves reads. Assumes condition checks and register access
// happen upstream; no flags are produced.
module pkmac_unit
    import pkmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic [DATA_W-1:0] wr_lo,
    input  logic [DATA_W-1:0] wr_hi,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_lo,
    output logic [DATA_W-1:0] rd_hi,
    output logic              done
);
    localparam int unsigned TOP_W = ACC_W - DATA_W;

    logic [ACC_W-1:0] addend, acc_q, load_val;
    logic             is_mac, add_en, load_en;

    // Enables for the accumulator from strobe and op code.
    assign add_en   = in_valid && is_mac;
    assign load_en  = in_valid && (in_op == OP_LOAD);
    assign load_val = {wr_hi[TOP_W-1:0], wr_lo};

    pkmac_addend #(.P_ACC_W(ACC_W), .P_DATA_W(DATA_W), .P_HALF_W(HALF_W)) u_addend (
        .op(in_op), .a(opnd_a), .b(opnd_b), .sel_a(sel_a), .sel_b(sel_b),
        .addend(addend), .is_mac(is_mac)
    );

    pkmac_acc #(.P_ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .add_en(add_en), .load_en(load_en),
        .addend(addend), .load_val(load_val), .acc_q(acc_q)
    );

    pkmac_readout #(.P_ACC_W(ACC_W), .P_DATA_W(DATA_W)) u_readout (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .any_req(in_valid || rd_req),
        .acc(acc_q), .rd_lo(rd_lo), .rd_hi(rd_hi), .done(done)
    );

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid || rd_req) |=> done);
    assert_enables_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({add_en, load_en}) <= 1);
endmodule

// File: tb/pkmac_unit_tb.sv
module pkmac_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0, wr_lo = '0, wr_hi = '0;
    logic        sel_a = 1'b0, sel_b = 1'b0, rd_req = 1'b0;
    logic [31:0] rd_lo, rd_hi;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    logic [39:0] model = '0;

    always #10 clk = ~clk;

    pkmac_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sel_a(sel_a), .sel_b(sel_b),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_req(rd_req),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .done(done)
    );

    // Vector: {op[2:0], a[31:0], b[31:0], sel_a, sel_b}; for op 3, a=wr_lo, b=wr_hi.
    localparam int NV = 12;
    localparam logic [68:0] VEC [NV] = '{
        {3'd3, 32'h1234_5678, 32'hABCD_EF9A, 1'b0, 1'b0},
        {3'd0, 32'h0000_0003, 32'hFFFF_FFFB, 1'b0, 1'b0},
        {3'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0},
        {3'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0},
        {3'd1, 32'h8000_8000, 32'h8000_8000, 1'b0, 1'b0},
        {3'd1, 32'h0002_FFFF, 32'hFFFD_0007, 1'b0, 1'b0},
        {3'd2, 32'h0003_FFFE, 32'h0005_0007, 1'b1, 1'b0},
        {3'd2, 32'h0003_FFFE, 32'h0005_0007, 1'b0, 1'b1},
        {3'd2, 32'h8000_0001, 32'h7FFF_0002, 1'b1, 1'b1},
        {3'd2, 32'h8000_0001, 32'h7FFF_0002, 1'b0, 1'b0},
        {3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1},
        {3'd7, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0}
    };

    function automatic logic [39:0] sx16(input logic [15:0] h);
        return {{24{h[15]}}, h};
    endfunction

    // Reference behaviour written from the requirements.
    function automatic logic [39:0] next_model(input logic [39:0] cur, input logic [2:0] op,
        input logic [31:0] a, input logic [31:0] b, input logic sa, input logic sb);
        longint p;
        int     q;
        case (op)
            3'd0: begin p = longint'($signed(a)) * longint'($signed(b)); return cur + p[39:0]; end
            3'd1: return cur + sx16(16'(($signed(a[15:0]) * $signed(b[15:0])) >>> 0)) * 0
                     + 40'($signed(32'($signed(a[15:0]) * $signed(b[15:0]))))
                     + 40'($signed(32'($signed(a[31:16]) * $signed(b[31:16]))));
            3'd2: begin
                q = $signed(sa ? a[31:16] : a[15:0]) * $signed(sb ? b[31:16] : b[15:0]);
                return cur + 40'($signed(q));
            end
            3'd3: return {b[7:0], a};
            default: return cur;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sa, input logic sb, input logic rd);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; opnd_a = a; opnd_b = b; sel_a = sa; sel_b = sb;
        wr_lo = a; wr_hi = b; rd_req = rd;
        @(negedge clk);
        in_valid = 1'b0; rd_req = 1'b0;
    endtask

    task automatic read_back(input string req, input logic [39:0] exp);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check({req, " lo"}, rd_lo, exp[31:0]);
        check({req, " hi"}, rd_hi, {{24{exp[39]}}, exp[39:32]});
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 done", {31'd0, done}, 32'd0);
        check("R10 rd_lo", rd_lo, 32'd0);
        rst_n = 1'b1;
        read_back("R10 acc after reset", 40'd0);

        // Table walk: R1 R2 R3 R5 R9 under varied patterns
        for (int i = 0; i < NV; i++) begin
            logic [68:0] v;
            v = VEC[i];
            model = next_model(model, v[68:66], v[65:34], v[33:2], v[1], v[0]);
            issue(v[68:66], v[65:34], v[33:2], v[1], v[0], 1'b0);
            check("R8 done after op", {31'd0, done}, 32'd1);
            read_back($sformatf("R1/R2/R3/R5/R9 vector %0d", i), model);
        end

        // R8: done low when idle
        @(negedge clk);
        check("R8 done idle", {31'd0, done}, 32'd0);

        // R4: wrap from +max to -2^39, and from -1 to 0
        issue(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FF7F, 1'b0, 1'b0, 1'b0);
        issue(3'd0, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0);
        read_back("R4 wrap to negative", 40'h80_0000_0000);
        check("R4 sign extension hi", rd_hi, 32'hFFFF_FF80);
        issue(3'd3, 32'hFFFF_FFFF, 32'h0000_00FF, 1'b0, 1'b0, 1'b0);
        issue(3'd2, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
        read_back("R4 wrap to zero", 40'd0);

        // R2: dual negative halves cross bit 31 -> positive 0x80000000
        issue(3'd1, 32'h8000_8000, 32'h8000_8000, 1'b0, 1'b0, 1'b0);
        read_back("R2 dual crossing bit 31", 40'h00_8000_0000);

        // R7: read with a MAC in the same cycle returns the prior value
        issue(3'd0, 32'd10, 32'd10, 1'b0, 1'b0, 1'b1);
        check("R7 read before update lo", rd_lo, 32'h8000_0000);
        check("R8 done on read+op", {31'd0, done}, 32'd1);
        read_back("R7 value after update", 40'h00_8000_0064);

        // R6: outputs held without a read
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'd3; wr_lo = 32'h0; wr_hi = 32'h0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 held lo", rd_lo, 32'h8000_0064);
        read_back("R5 load zero", 40'd0);

        // R9: valid low with a MAC op pattern does nothing
        @(negedge clk);
        in_op = 3'd0; opnd_a = 32'd7; opnd_b = 32'd9;
        @(negedge clk);
        read_back("R9 valid low", 40'd0);

        // R10: reset mid-run clears a loaded value
        issue(3'd3, 32'hDEAD_BEEF, 32'h0000_0042, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid reset rd_lo", rd_lo, 32'd0);
        rst_n = 1'b1;
        read_back("R10 mid reset acc", 40'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule